// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one timer channel on a simple register bus. Software programs a reload value and a starting count, selects a prescale ratio, and sets the run bit. While running, the count drops by one on every prescaled tick. When a tick arrives with the count already at zero, the counter takes the reload value and keeps going, which gives a steady periodic tick. Each of these underflows sets a sticky flag, and that flag can drive a level interrupt.

The usual setup is periodic: reload and count both hold the interval and the interrupt is enabled. The other setup is a free-running measurement: both registers hold all ones, interrupts are off, and software reads the live count. The prescale ratio is four times a power of four, chosen by a 3-bit field. The interrupt handler clears the flag by writing the control register with the flag bit at zero.

Top module: `dn_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: The bus has four word addresses: 0 is run control (bit 0 is the run bit), 1 is control, 2 is reload, 3 is count. Reload and count are read and written as full 32-bit values. Control keeps bits 2:0 (prescale select), bit 5 (interrupt enable) and bit 8 (underflow flag); every other bit reads as zero.
- R3: While the run bit is 0, the count holds its value and a bus write loads it.
- R4: While running, the count decrements once every 4 << (2*select) clock cycles. The first decrement lands exactly that many cycles after the clock edge that sets the run bit.
- R5: A tick that finds the count at zero loads the reload value instead of wrapping. Counting continues, so the reload-to-reload period is (reload+1) ticks.
- R6: An underflow sets the flag. The flag stays set until a control write with bit 8 at 0. A control write with bit 8 at 1 leaves the flag unchanged.
- R7: If an underflow and a clearing control write happen on the same edge, the flag stays set.
- R8: `irq` is high exactly when the flag and the interrupt enable are both set, and it stays high as long as both are set.
- R9: Clearing the run bit resets the prescale divider. After a restart, the first decrement comes a full ratio later, whatever phase the divider had when it stopped.
- R10: A count write while running replaces the count at once. The next decrement follows the divider phase, which the write does not disturb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: underflow flag AND enable |

## Verification
The hardest case to reach from the ports is a clearing control write that lands on the very edge of an underflow. The stimulus gets there by running at the smallest ratio with a reload of zero, so an underflow falls on every fourth edge. The bench counts edges from the run write and places the clear on an underflow edge, then places a second clear one edge later. The sweeps over select values and small reload values compare every sampled count and flag with a closed-form tick count. The divider-reset case stops the channel in mid-period and measures when the first decrement arrives after the restart.

// File: rtl/dn_timer_pkg.sv
// Shared register addresses and control-field positions for the timer channel.
// Assumes a word-addressed bus with a 2-bit address.
package dn_timer_pkg;
    typedef enum logic [1:0] {
        REG_RUN   = 2'd0,
        REG_CTRL  = 2'd1,
        REG_RELD  = 2'd2,
        REG_COUNT = 2'd3
    } reg_addr_e;

    localparam int SEL_LSB  = 0;   // prescale select field base
    localparam int IE_BIT   = 5;   // interrupt enable
    localparam int FLAG_BIT = 8;   // sticky underflow flag
    localparam int RUN_BIT  = 0;   // run bit in run-control register
endpackage

// File: rtl/dn_timer_psc.sv
// Prescaler: emits a one-cycle tick every 4 << (2*sel) cycles while run is high.
// Assumes run gates counting; the divider returns to zero whenever run is low.
module dn_timer_psc #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = 2 * ((1 << SEL_W) - 1) + 2;
    localparam int SH_W  = SEL_W + 2;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    logic [SH_W-1:0]  shamt;

    // Build the low-bit mask whose all-ones state marks the end of a period.
    always_comb begin
        shamt = {1'b0, sel, 1'b0} + SH_W'(2);
        mask  = ~({DIV_W{1'b1}} << shamt);
    end

    // Free divider, held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    assign tick = run && ((div_q & mask) == mask);
endmodule

// File: rtl/dn_timer_cnt.sv
// Down-counter with reload: decrements on tick and reloads from rld at zero.
// Assumes a bus load has priority over a tick in the same cycle.
module dn_timer_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] rld,
    output logic [W-1:0] cnt,
    output logic         unf
);
    logic at_zero;
    assign at_zero = (cnt == '0);
    assign unf     = tick && at_zero && !load_en;

    // Count register: bus load, else tick-driven decrement or reload.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load_en) cnt <= load_val;
        else if (tick)    cnt <= at_zero ? rld : cnt - 1'b1;
    end
endmodule

// File: rtl/dn_timer_flag.sv
// Sticky underflow flag: set by hardware, cleared by software; set wins.
// Assumes clr is already qualified to a control write carrying a zero flag bit.
module dn_timer_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Flag state with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/dn_timer.sv
// Timer channel top: register decode, read mux and interrupt.
// Assumes one-cycle writes and a combinational read path.
module dn_timer
    import dn_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    logic             start_q;
    logic             ie_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] const_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             unf;
    logic             flag_q;
    logic             run_wr, ctl_wr, rld_wr, cnt_wr;

    assign run_wr = bus_we && (bus_addr == REG_RUN);
    assign ctl_wr = bus_we && (bus_addr == REG_CTRL);
    assign rld_wr = bus_we && (bus_addr == REG_RELD);
    assign cnt_wr = bus_we && (bus_addr == REG_COUNT);

    // Software-owned configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            ie_q    <= 1'b0;
            sel_q   <= '0;
            const_q <= '0;
        end else begin
            if (run_wr) start_q <= bus_wdata[RUN_BIT];
            if (ctl_wr) begin
                ie_q  <= bus_wdata[IE_BIT];
                sel_q <= bus_wdata[SEL_LSB +: SEL_W];
            end
            if (rld_wr) const_q <= bus_wdata;
        end
    end

    dn_timer_psc #(.SEL_W(SEL_W)) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (start_q),
        .sel  (sel_q),
        .tick (tick)
    );

    dn_timer_cnt #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load_en (cnt_wr),
        .load_val(bus_wdata),
        .rld     (const_q),
        .cnt     (cnt_q),
        .unf     (unf)
    );

    dn_timer_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (unf),
        .clr  (ctl_wr && !bus_wdata[FLAG_BIT]),
        .flag (flag_q)
    );

    // Read mux over the four registers.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_RUN:   bus_rdata[RUN_BIT] = start_q;
            REG_CTRL: begin
                bus_rdata[SEL_LSB +: SEL_W] = sel_q;
                bus_rdata[IE_BIT]           = ie_q;
                bus_rdata[FLAG_BIT]         = flag_q;
            end
            REG_RELD:  bus_rdata = const_q;
            REG_COUNT: bus_rdata = cnt_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = flag_q && ie_q;
endmodule

// File: rtl/dn_timer_chk.sv
// Property checker for the timer channel, bound into dn_timer.
// Assumes it observes internal register state through the bind connections.
module dn_timer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         tick,
    input logic [W-1:0] cnt,
    input logic [W-1:0] const_v,
    input logic         flag,
    input logic         ie,
    input logic         irq,
    input logic         cnt_wr,
    input logic         ctl_wr
);
    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != '0 && !cnt_wr) |=> (cnt == $past(cnt) - 1'b1));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && !cnt_wr) |=> (cnt == $past(const_v)));

    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && !cnt_wr) |=> flag);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ctl_wr) |=> flag);

    p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && !cnt_wr && ie && !ctl_wr) |=> irq);
endmodule

bind dn_timer dn_timer_chk #(.W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (start_q),
    .tick   (tick),
    .cnt    (cnt_q),
    .const_v(const_q),
    .flag   (flag_q),
    .ie     (ie_q),
    .irq    (irq),
    .cnt_wr (cnt_wr),
    .ctl_wr (ctl_wr)
);

// File: tb/dn_timer_tb.sv
// Self-checking bench: sweeps select and reload values, plus flag corner cases.
module dn_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    int t = 0;

    always #5 clk = ~clk;

    dn_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // Write lands on the next rising edge; returns at the following negedge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        t++;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
        t += n;
    endtask

    function automatic int exp_cnt(input int k, input int n);
        if (n <= k) return k - n;
        return k - ((n - k - 1) % (k + 1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 reset register", v, 32'd0);
        end
        check("R1 irq after reset", {31'd0, irq}, 32'd0);

        // R2 readback of all registers
        wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); check("R2 reload readback", v, 32'hFFFF_FFFF);
        wr(2'd3, 32'hA5A5_5A5A); rd(2'd3, v); check("R2 count readback", v, 32'hA5A5_5A5A);
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R2 control mask, flag write-1 keeps 0", v, 32'h0000_0027);
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); check("R2 run bit readback", v, 32'd1);
        wr(2'd0, 32'd0);

        // R3 load and hold while stopped
        wr(2'd3, 32'h55); adv(40); rd(2'd3, v); check("R3 hold while stopped", v, 32'h55);

        // R4 / R5 / R6 sweep: select 0..2, reload 0..3
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < 4; k++) begin
                int ratio;
                ratio = 4 << (2 * s);
                wr(2'd0, 32'd0);
                wr(2'd1, s);          // flag cleared, irq disabled
                wr(2'd2, k);
                wr(2'd3, k);
                wr(2'd0, 32'd1);
                t = 0;
                for (int j = 1; j <= k + 2; j++) begin
                    for (int off = 1; off >= 0; off--) begin
                        int tgt, n;
                        tgt = j * ratio - off;
                        adv(tgt - t);
                        n = t / ratio;
                        rd(2'd3, v);
                        check($sformatf("R4/R5 count sel=%0d k=%0d t=%0d", s, k, t), v, exp_cnt(k, n));
                        rd(2'd1, v);
                        check($sformatf("R6 flag sel=%0d k=%0d t=%0d", s, k, t), {31'd0, v[8]}, (n > k) ? 32'd1 : 32'd0);
                    end
                end
            end
        end

        // Free-running measurement from all ones
        wr(2'd0, 32'd0); wr(2'd1, 32'd0);
        wr(2'd2, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);
        wr(2'd0, 32'd1); t = 0;
        adv(40); rd(2'd3, v); check("R4 free-running count", v, 32'hFFFF_FFFF - 32'd10);

        // R9 divider reset on stop (ratio 16)
        wr(2'd0, 32'd0); wr(2'd1, 32'd1); wr(2'd2, 32'd1000); wr(2'd3, 32'd1000);
        wr(2'd0, 32'd1); t = 0;
        adv(9); wr(2'd0, 32'd0);            // stop at edge 10, before the first tick
        adv(20); rd(2'd3, v); check("R3 hold after stop", v, 32'd1000);
        wr(2'd0, 32'd1); t = 0;
        adv(15); rd(2'd3, v); check("R9 no tick before full ratio", v, 32'd1000);
        adv(1);  rd(2'd3, v); check("R9 tick at full ratio", v, 32'd999);

        // R10 count write while running (ratio 4)
        wr(2'd0, 32'd0); wr(2'd1, 32'd0); wr(2'd3, 32'd500);
        wr(2'd0, 32'd1); t = 0;
        wr(2'd3, 32'd100); rd(2'd3, v); check("R10 write replaces count", v, 32'd100);
        adv(3); rd(2'd3, v); check("R10 decrement on divider phase", v, 32'd99);
        adv(4); rd(2'd3, v); check("R10 next decrement", v, 32'd98);

        // R7 / R8 / R6 flag and interrupt corners: ratio 4, reload 0
        wr(2'd0, 32'd0); wr(2'd1, 32'h20); wr(2'd2, 32'd0); wr(2'd3, 32'd0);
        wr(2'd0, 32'd1); t = 0;
        adv(3); check("R8 irq low before underflow", {31'd0, irq}, 32'd0);
        adv(1); check("R8 irq high after underflow", {31'd0, irq}, 32'd1);
        adv(3); wr(2'd1, 32'h20);           // clear lands on underflow edge 8
        rd(2'd1, v); check("R7 underflow beats clear", {31'd0, v[8]}, 32'd1);
        check("R8 irq stays high", {31'd0, irq}, 32'd1);
        wr(2'd1, 32'h20);                   // clear at edge 9
        rd(2'd1, v); check("R6 clear by zero write", {31'd0, v[8]}, 32'd0);
        check("R8 irq drops with flag", {31'd0, irq}, 32'd0);
        adv(3); rd(2'd1, v); check("R6 flag set again", {31'd0, v[8]}, 32'd1);
        wr(2'd1, 32'h120);                  // edge 13, write one
        rd(2'd1, v); check("R6 write one keeps flag", {31'd0, v[8]}, 32'd1);
        wr(2'd1, 32'h000);                  // edge 14, clear and disable
        check("R8 irq low when disabled", {31'd0, irq}, 32'd0);
        adv(2); rd(2'd1, v); check("R6 flag set at edge 16", {31'd0, v[8]}, 32'd1);
        check("R8 enable gates irq", {31'd0, irq}, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule